// File: doc/BRIEF.md
# Shift-Scaled Min-Sum Check Node Unit

This unit performs the check-node half of a normalized min-sum decoder for one parity-check row with 32 edges. All incoming variable-to-check messages arrive together as one parallel vector with a valid strobe. Every message is an 8-bit two's-complement value with 4 fraction bits, so its range is roughly -8 to +8. For every edge the unit returns a check-to-variable message in the same format. That message carries the sign product of the other 31 inputs. Its magnitude is the smallest magnitude among those 31 inputs, multiplied by a normalization factor.

The factor is chosen for each vector by a 2-bit mode input, so a controller can change it from one iteration to the next. No multiplier is used. Each factor is built as a sum of at most three right-shifted copies of the magnitude. Inside the unit only four things are kept for the whole row: the smallest magnitude, the second-smallest magnitude, the position of the smallest, and the parity of all the sign bits. Each output lane is then rebuilt from these four values.

Top module: `cnu_minsum`

## Requirements
- R1: A vector accepted with `in_valid` high produces its result with `out_valid` high exactly two clock cycles later. Vectors can be accepted on consecutive cycles, and each result appears in the same order as its input.
- R2: For edge e, the unscaled output magnitude is the minimum magnitude over all edges except e. Edge e occupies bits [8e+7:8e] of both `in_msgs` and `out_msgs`.
- R3: The sign of edge e's output is the XOR of bit 7 of every other edge's input. When the scaled magnitude is zero, the output lane is 0.
- R4: When two or more edges share the smallest magnitude, every edge receives that magnitude, including the edges that hold it.
- R5: An input of -128 counts as magnitude 127. No output lane ever equals -128.
- R6: With mode 2'b00, the scaled magnitude equals the magnitude (factor 1).
- R7: With mode 2'b01, the scaled magnitude is m/2 + m/4 + m/8. Each term uses integer division that truncates (factor 0.875).
- R8: With mode 2'b10, the scaled magnitude is m/2 + m/4, each term truncated (factor 0.75).
- R9: With mode 2'b11, the scaled magnitude is m/2, truncated (factor 0.5).
- R10: While reset is held and directly after it, `out_valid` is 0 and `out_msgs` is all zeros.
- R11: While `in_valid` is low, `in_msgs` and `in_mode` are ignored. `out_valid` stays low two cycles later and `out_msgs` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input vector and mode are valid this cycle |
| in_msgs | input | 256 | 32 variable-to-check messages, edge e in bits [8e+7:8e] |
| in_mode | input | 2 | Normalization factor select: 00=1, 01=0.875, 10=0.75, 11=0.5 |
| out_valid | output | 1 | Result vector is valid |
| out_msgs | output | 256 | 32 check-to-variable messages, same packing as input |

## Verification
Every result is due exactly two rising edges after its vector was sampled. The first edge registers the row minima and the sign parity. The second edge registers the scaled output lanes. The driver stamps each expected vector with the cycle number at which it was applied. The monitor samples on falling edges and checks that each result arrives exactly two cycles after its stamp, as well as checking its content. The check for ignored input waits more than two cycles after the last valid vector before it compares the held output.

// File: rtl/cnu_pkg.sv
package cnu_pkg;

  typedef enum logic [1:0] {
    SCL_ONE   = 2'b00,
    SCL_SEVEN = 2'b01,
    SCL_THREE = 2'b10,
    SCL_HALF  = 2'b11
  } scale_mode_e;

  // Normalization by shift-and-add; each shifted term truncates on its own.
  function automatic logic [15:0] shift_scale(input logic [15:0] mag, input scale_mode_e md);
    logic [15:0] r;
    case (md)
      SCL_ONE:   r = mag;
      SCL_SEVEN: r = (mag >> 1) + (mag >> 2) + (mag >> 3);
      SCL_THREE: r = (mag >> 1) + (mag >> 2);
      default:   r = mag >> 1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cnu_magsign.sv
module cnu_magsign #(
  parameter int MSG_W = 8,
  localparam int MAG_W = MSG_W - 1
) (
  input  logic [MSG_W-1:0] msg,
  output logic             sgn,
  output logic [MAG_W-1:0] mag
);
  logic [MSG_W-1:0] negated;
  logic             is_most_neg;

  assign negated     = MSG_W'(-msg);
  assign is_most_neg = (msg == {1'b1, {MAG_W{1'b0}}});
  assign sgn         = msg[MSG_W-1];

  // R5: the most negative code saturates to the largest magnitude
  always_comb begin
    if (is_most_neg)          mag = {MAG_W{1'b1}};
    else if (msg[MSG_W-1])    mag = negated[MAG_W-1:0];
    else                      mag = msg[MAG_W-1:0];
  end
endmodule

// File: rtl/cnu_minfind.sv
module cnu_minfind #(
  parameter int DEG   = 32,
  parameter int MAG_W = 7,
  localparam int IDX_W = $clog2(DEG)
) (
  input  logic [DEG*MAG_W-1:0] mags,
  input  logic [DEG-1:0]       sgns,
  output logic [MAG_W-1:0]     min1,
  output logic [MAG_W-1:0]     min2,
  output logic [IDX_W-1:0]     min_idx,
  output logic                 parity
);
  // Strict compare keeps the lowest index on ties and lets min2 equal min1 (R4).
  always_comb begin
    min1    = {MAG_W{1'b1}};
    min2    = {MAG_W{1'b1}};
    min_idx = '0;
    for (int i = 0; i < DEG; i++) begin
      if (mags[i*MAG_W +: MAG_W] < min1) begin
        min2    = min1;
        min1    = mags[i*MAG_W +: MAG_W];
        min_idx = IDX_W'(i);
      end else if (mags[i*MAG_W +: MAG_W] < min2) begin
        min2 = mags[i*MAG_W +: MAG_W];
      end
    end
  end

  assign parity = ^sgns;
endmodule

// File: rtl/cnu_outlane.sv
module cnu_outlane
  import cnu_pkg::*;
#(
  parameter int DEG   = 32,
  parameter int MSG_W = 8,
  parameter int LANE  = 0,
  localparam int MAG_W = MSG_W - 1,
  localparam int IDX_W = $clog2(DEG)
) (
  input  logic [MAG_W-1:0] min1,
  input  logic [MAG_W-1:0] min2,
  input  logic [IDX_W-1:0] min_idx,
  input  logic             parity,
  input  logic             own_sgn,
  input  scale_mode_e      mode,
  output logic [MAG_W-1:0] sel_mag,
  output logic [MAG_W-1:0] scaled_mag,
  output logic [MSG_W-1:0] msg
);
  logic             neg;
  logic [MSG_W-1:0] pos_msg;

  // R2: the edge holding the minimum takes the runner-up
  assign sel_mag    = (min_idx == IDX_W'(LANE)) ? min2 : min1;
  assign scaled_mag = MAG_W'(shift_scale(16'(sel_mag), mode));
  // R3: removing own sign from total parity leaves the product of the others
  assign neg        = parity ^ own_sgn;
  assign pos_msg    = {1'b0, scaled_mag};
  assign msg        = neg ? MSG_W'(-pos_msg) : pos_msg;
endmodule

// File: rtl/cnu_minsum.sv
module cnu_minsum
  import cnu_pkg::*;
#(
  parameter int DEG   = 32,
  parameter int MSG_W = 8,
  localparam int MAG_W = MSG_W - 1,
  localparam int IDX_W = $clog2(DEG),
  localparam int VEC_W = DEG * MSG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] in_msgs,
  input  logic [1:0]       in_mode,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_msgs
);
  logic [DEG*MAG_W-1:0] in_mags;
  logic [DEG-1:0]       in_sgns;
  logic [MAG_W-1:0]     c_min1, c_min2;
  logic [IDX_W-1:0]     c_idx;
  logic                 c_par;

  logic                 s1_valid;
  logic [MAG_W-1:0]     s1_min1, s1_min2;
  logic [IDX_W-1:0]     s1_idx;
  logic                 s1_par;
  logic [DEG-1:0]       s1_sgns;
  scale_mode_e          s1_mode;

  logic [VEC_W-1:0]     lane_msgs;
  logic [DEG*MAG_W-1:0] lane_sel;
  logic [DEG*MAG_W-1:0] lane_scaled;

  for (genvar e = 0; e < DEG; e++) begin : g_split
    cnu_magsign #(.MSG_W(MSG_W)) u_ms (
      .msg (in_msgs[e*MSG_W +: MSG_W]),
      .sgn (in_sgns[e]),
      .mag (in_mags[e*MAG_W +: MAG_W])
    );
  end

  cnu_minfind #(.DEG(DEG), .MAG_W(MAG_W)) u_min (
    .mags    (in_mags),
    .sgns    (in_sgns),
    .min1    (c_min1),
    .min2    (c_min2),
    .min_idx (c_idx),
    .parity  (c_par)
  );

  // Stage 1: row summary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_min1  <= '0;
      s1_min2  <= '0;
      s1_idx   <= '0;
      s1_par   <= 1'b0;
      s1_sgns  <= '0;
      s1_mode  <= SCL_ONE;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_min1 <= c_min1;
        s1_min2 <= c_min2;
        s1_idx  <= c_idx;
        s1_par  <= c_par;
        s1_sgns <= in_sgns;
        s1_mode <= scale_mode_e'(in_mode);
      end
    end
  end

  for (genvar e = 0; e < DEG; e++) begin : g_lane
    cnu_outlane #(.DEG(DEG), .MSG_W(MSG_W), .LANE(e)) u_lane (
      .min1       (s1_min1),
      .min2       (s1_min2),
      .min_idx    (s1_idx),
      .parity     (s1_par),
      .own_sgn    (s1_sgns[e]),
      .mode       (s1_mode),
      .sel_mag    (lane_sel[e*MAG_W +: MAG_W]),
      .scaled_mag (lane_scaled[e*MAG_W +: MAG_W]),
      .msg        (lane_msgs[e*MSG_W +: MSG_W])
    );

    a_r6_scale_bound: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |-> lane_scaled[e*MAG_W +: MAG_W] <= lane_sel[e*MAG_W +: MAG_W]);
    a_r5_no_most_neg: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_msgs[e*MSG_W +: MSG_W] != {1'b1, {MAG_W{1'b0}}});
  end

  // Stage 2: scaled output lanes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_msgs  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_msgs <= lane_msgs;
    end
  end

  a_r1_stage1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid);
  a_r1_stage2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !out_valid);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> $stable(out_msgs));
  a_r4_min_order: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> s1_min1 <= s1_min2);
endmodule

// File: tb/cnu_minsum_tb.sv
module cnu_minsum_tb;
  localparam int DEG = 32;
  localparam int W   = 8;
  localparam int VW  = DEG * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [VW-1:0] in_msgs = '0;
  logic [1:0]    in_mode = 2'b00;
  logic          out_valid;
  logic [VW-1:0] out_msgs;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  logic [VW-1:0] exp_q[$];
  string         tag_q[$];
  int            stamp_q[$];

  cnu_minsum u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_msgs(in_msgs),
    .in_mode(in_mode), .out_valid(out_valid), .out_msgs(out_msgs)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int mag_of(input logic [7:0] v);
    int s;
    s = $signed(v);
    if (s == -128) return 127;
    return (s < 0) ? -s : s;
  endfunction

  function automatic int scale_of(input int m, input logic [1:0] md);
    case (md)
      2'b00: return m;
      2'b01: return m / 2 + m / 4 + m / 8;
      2'b10: return m / 2 + m / 4;
      default: return m / 2;
    endcase
  endfunction

  function automatic logic [VW-1:0] model(input logic [VW-1:0] v, input logic [1:0] md);
    logic [VW-1:0] r;
    for (int e = 0; e < DEG; e++) begin
      int mn;
      logic ng;
      int res;
      mn = 1000;
      ng = 1'b0;
      for (int j = 0; j < DEG; j++) begin
        if (j != e) begin
          if (mag_of(v[j*W +: W]) < mn) mn = mag_of(v[j*W +: W]);
          ng = ng ^ v[j*W + W - 1];
        end
      end
      res = scale_of(mn, md);
      if (ng) res = -res;
      r[e*W +: W] = 8'(res);
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [VW-1:0] v, input logic [1:0] md, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_msgs  = v;
    in_mode  = md;
    exp_q.push_back(model(v, md));
    tag_q.push_back(tag);
    stamp_q.push_back(cyc);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_msgs  = {8{32'hDEAD_BEEF}};
      in_mode  = 2'b11;
    end
  endtask

  // Monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected out_valid", out_msgs, '0);
      end else begin
        logic [VW-1:0] e;
        string t;
        int st;
        e  = exp_q.pop_front();
        t  = tag_q.pop_front();
        st = stamp_q.pop_front();
        check(cyc - st == 2, "R1 latency", VW'(cyc - st), VW'(2));
        check(out_msgs === e, t, out_msgs, e);
      end
    end
  end

  initial begin
    logic [VW-1:0] v;
    logic [VW-1:0] held;

    // R10: reset state
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && out_msgs === '0, "R10 reset", {out_valid, out_msgs[VW-2:0]}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && out_msgs === '0, "R10 after reset", {out_valid, out_msgs[VW-2:0]}, '0);

    // R2/R6: distinct positive magnitudes
    for (int e = 0; e < DEG; e++) v[e*W +: W] = 8'(10 + 3 * e);
    send(v, 2'b00, "R2 R6 distinct positive");
    // R3: alternating signs
    for (int e = 0; e < DEG; e++) v[e*W +: W] = (e % 2 == 1) ? 8'(-(10 + 3 * e)) : 8'(10 + 3 * e);
    send(v, 2'b00, "R3 alternating signs");
    // R4: shared minimum
    for (int e = 0; e < DEG; e++) v[e*W +: W] = 8'd40;
    v[5*W +: W]  = 8'(-20);
    v[20*W +: W] = 8'(-20);
    send(v, 2'b00, "R4 tied minimum");
    // R5: all most-negative codes
    for (int e = 0; e < DEG; e++) v[e*W +: W] = 8'h80;
    send(v, 2'b00, "R5 saturation all");
    // R5: mix of extremes
    for (int e = 0; e < DEG; e++) v[e*W +: W] = (e % 3 == 0) ? 8'h80 : 8'h7F;
    send(v, 2'b00, "R5 saturation mix");
    // R3: zero input forces zero outputs elsewhere
    for (int e = 0; e < DEG; e++) v[e*W +: W] = 8'(-50);
    v[7*W +: W] = 8'h00;
    send(v, 2'b00, "R3 zero magnitude");
    // R7-R9 modes on odd magnitudes
    for (int e = 0; e < DEG; e++) v[e*W +: W] = 8'(99 + 2 * (e % 5));
    send(v, 2'b01, "R7 mode 0.875");
    send(v, 2'b10, "R8 mode 0.75");
    send(v, 2'b11, "R9 mode 0.5");
    for (int e = 0; e < DEG; e++) v[e*W +: W] = 8'(-(3 + e));
    send(v, 2'b01, "R7 small magnitude");
    send(v, 2'b10, "R8 small magnitude");
    send(v, 2'b11, "R9 small magnitude");
    idle(4);

    // R1: back-to-back random burst
    for (int k = 0; k < 24; k++) begin
      for (int e = 0; e < DEG; e++) v[e*W +: W] = 8'($urandom);
      send(v, 2'($urandom), "R1 R2 burst");
    end
    idle(5);

    // R11: inputs ignored while not valid
    held = out_msgs;
    idle(4);
    check(out_valid === 1'b0 && out_msgs === held, "R11 hold", out_msgs, held);
    check(exp_q.size() == 0, "R1 all results delivered", VW'(exp_q.size()), '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 5000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule